// File: doc/BRIEF.md
# Processor-to-ZBT SRAM bridge

This block sits between a processor memory port built for plain asynchronous SRAM and a synchronous, pipelined zero-bus-turnaround SRAM. The processor side has an active-low chip select, an active-low read output enable, an active-low write enable, a byte address, active-low byte-lane write strobes and 32-bit write data. The memory side carries a clock, clock enable, chip enable, output enable, a read/write direction line, an advance/load line, one active-low write enable per byte lane, a word address and a shared bidirectional data bus.

The processor's byte address is turned into a word address by dropping its two lowest bits. Each accepted request is registered onto the memory control pins one clock later. The data phase follows that address cycle two clocks later. In that phase the bridge drives write data, or it enables the memory's output and captures read data. Reads and writes may follow each other on consecutive cycles in any order, and no idle cycle is needed between them.

Flow rules: the request side has no back-pressure. A request is taken on every rising edge on which it is present. Read data returns as a valid-only stream (`rd_valid`, `rd_data`) at a fixed latency. The consumer must accept it in the cycle it appears, because the memory pipeline cannot be stalled.

Top module: `zbt_bridge`

## Requirements
- R1: On a rising edge with `cpu_sel_n` low, a low `cpu_wr_n` makes a write. With `cpu_sel_n` low, `cpu_wr_n` high and `cpu_rd_n` low makes a read. Any other combination is idle, including `cpu_sel_n` high with strobes low. In the cycle after the edge, `mem_ce_n` is low for an access and high for idle.
- R2: For an access, `mem_addr` in the following cycle equals `cpu_addr[WADDR_W+1:2]`. Byte-address bits [1:0] have no effect on the memory side.
- R3: For a write, in the following cycle `mem_rw_n` is low and `mem_bw_n` equals `cpu_be_n` without inversion. Bit i controls data bits [8i+7:8i], and a low bit writes that lane.
- R4: The write data of a request sampled at edge k is driven on `mem_dq` from edge k+2 to edge k+3. The bridge drives the bus in no other cycle.
- R5: For a read, `mem_rw_n` is high and `mem_bw_n` is all ones in the address cycle. `mem_oe_n` is low from edge k+2 to edge k+3. `rd_valid` is high for one cycle from edge k+3, and `rd_data` then holds the addressed word.
- R6: `mem_oe_n` is never low in a cycle in which the bridge drives `mem_dq`.
- R7: Reads and writes in any order on consecutive cycles are all carried out in issue order. A read directly after a write to the same word returns the new data. A read directly before a write returns the old data.
- R8: `mem_cke_n` and `mem_adv_ld_n` are held low, and `mem_clk` follows `clk`.
- R9: While `rst_n` is low, `mem_ce_n` and `mem_oe_n` are high, the bridge releases `mem_dq`, and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel_n | input | 1 | Processor chip select, active low |
| cpu_rd_n | input | 1 | Processor read output enable, active low |
| cpu_wr_n | input | 1 | Processor write enable, active low |
| cpu_addr | input | WADDR_W+2 | Processor byte address |
| cpu_be_n | input | DATA_W/8 | Byte-lane write strobes, active low |
| cpu_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle per read |
| rd_data | output | DATA_W | Returned read word |
| mem_clk | output | 1 | Memory clock |
| mem_cke_n | output | 1 | Memory clock enable, active low |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_rw_n | output | 1 | High read, low write |
| mem_adv_ld_n | output | 1 | Advance/load, low loads a new address |
| mem_bw_n | output | DATA_W/8 | Byte-lane write enables, active low |
| mem_addr | output | WADDR_W | Word address |
| mem_dq | inout | DATA_W | Bidirectional data bus |

## Verification
The assertions check on every cycle that the memory control pins follow the processor strobes one clock later. They also check that a write address cycle is followed two clocks later by the bridge driving the bus, that a read address cycle is followed by an output-enable phase and then a returned word, and that the output enable and the bridge's own bus drive never overlap. Only the bench's scenarios can show data integrity. These are byte-lane merging, correct words coming back from every address, and issue order under back-to-back read-after-write and write-after-read. Reading back through a behavioural memory stub shows all three.

// File: rtl/zbt_bridge_pkg.sv
package zbt_bridge_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zb_op_e;

  // clocks from the memory's address edge to its data edge
  localparam int DATA_LAG = 2;
  // bridge-side registers between the command register and the data-phase register
  localparam int MID_STAGES = DATA_LAG - 1;
endpackage

// File: rtl/zbt_cmd_issue.sv
module zbt_cmd_issue
  import zbt_bridge_pkg::*;
#(
  parameter int WADDR_W = 19,
  parameter int DATA_W  = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int PADDR_W = WADDR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_sel_n,
  input  logic               cpu_rd_n,
  input  logic               cpu_wr_n,
  input  logic [PADDR_W-1:0] cpu_addr,
  input  logic [LANES-1:0]   cpu_be_n,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               mem_ce_n,
  output logic               mem_rw_n,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]   mem_bw_n,
  output zb_op_e             op_q,
  output logic [DATA_W-1:0]  wdata_q
);
  zb_op_e op_d;

  always_comb begin
    op_d = OP_IDLE;
    if (!cpu_sel_n) begin
      if (!cpu_wr_n)      op_d = OP_WRITE;
      else if (!cpu_rd_n) op_d = OP_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n <= 1'b1;
      mem_rw_n <= 1'b1;
      mem_addr <= '0;
      mem_bw_n <= '1;
      op_q     <= OP_IDLE;
      wdata_q  <= '0;
    end else begin
      mem_ce_n <= (op_d == OP_IDLE);
      mem_rw_n <= (op_d != OP_WRITE);
      mem_addr <= cpu_addr[PADDR_W-1:2];
      mem_bw_n <= (op_d == OP_WRITE) ? cpu_be_n : '1;
      op_q     <= op_d;
      wdata_q  <= cpu_wdata;
    end
  end

  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel_n || (cpu_rd_n && cpu_wr_n)) |=> mem_ce_n);

  p_word_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_sel_n && !(cpu_rd_n && cpu_wr_n)) |=>
      (!mem_ce_n && mem_addr == $past(cpu_addr[PADDR_W-1:2])));

  p_write_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_sel_n && !cpu_wr_n) |=> (!mem_rw_n && mem_bw_n == $past(cpu_be_n)));

  p_read_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_sel_n && cpu_wr_n && !cpu_rd_n) |=> (mem_rw_n && mem_bw_n == '1));
endmodule

// File: rtl/zbt_lag_pipe.sv
module zbt_lag_pipe
  import zbt_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = MID_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  zb_op_e            op_i,
  input  logic [DATA_W-1:0] data_i,
  output zb_op_e            op_o,
  output logic [DATA_W-1:0] data_o
);
  zb_op_e            op_s   [DEPTH+1];
  logic [DATA_W-1:0] data_s [DEPTH+1];

  assign op_s[0]   = op_i;
  assign data_s[0] = data_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        op_s[g+1]   <= OP_IDLE;
        data_s[g+1] <= '0;
      end else begin
        op_s[g+1]   <= op_s[g];
        data_s[g+1] <= data_s[g];
      end
    end
  end

  assign op_o   = op_s[DEPTH];
  assign data_o = data_s[DEPTH];
endmodule

// File: rtl/zbt_data_phase.sv
module zbt_data_phase
  import zbt_bridge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  zb_op_e            op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              mem_oe_n,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      mem_oe_n <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      dq_oe    <= (op_i == OP_WRITE);
      dq_out   <= wdata_i;
      mem_oe_n <= (op_i != OP_READ);
      rd_valid <= !mem_oe_n;
      if (!mem_oe_n) rd_data <= dq_in;
    end
  end

  p_bus_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !mem_oe_n));
endmodule

// File: rtl/zbt_bridge.sv
module zbt_bridge
  import zbt_bridge_pkg::*;
#(
  parameter int WADDR_W = 19,
  parameter int DATA_W  = 32,
  localparam int LANES   = DATA_W / 8,
  localparam int PADDR_W = WADDR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_sel_n,
  input  logic               cpu_rd_n,
  input  logic               cpu_wr_n,
  input  logic [PADDR_W-1:0] cpu_addr,
  input  logic [LANES-1:0]   cpu_be_n,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               mem_clk,
  output logic               mem_cke_n,
  output logic               mem_ce_n,
  output logic               mem_oe_n,
  output logic               mem_rw_n,
  output logic               mem_adv_ld_n,
  output logic [LANES-1:0]   mem_bw_n,
  output logic [WADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0]  mem_dq
);
  zb_op_e            cmd_op, mid_op;
  logic [DATA_W-1:0] cmd_wdata, mid_wdata, dq_out;
  logic              dq_oe;

  assign mem_clk      = clk;
  assign mem_cke_n    = 1'b0;
  assign mem_adv_ld_n = 1'b0;
  assign mem_dq       = dq_oe ? dq_out : 'z;

  zbt_cmd_issue #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel_n(cpu_sel_n), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_addr(cpu_addr), .cpu_be_n(cpu_be_n), .cpu_wdata(cpu_wdata),
    .mem_ce_n(mem_ce_n), .mem_rw_n(mem_rw_n), .mem_addr(mem_addr),
    .mem_bw_n(mem_bw_n), .op_q(cmd_op), .wdata_q(cmd_wdata)
  );

  zbt_lag_pipe #(.DATA_W(DATA_W), .DEPTH(MID_STAGES)) u_lag (
    .clk(clk), .rst_n(rst_n),
    .op_i(cmd_op), .data_i(cmd_wdata),
    .op_o(mid_op), .data_o(mid_wdata)
  );

  zbt_data_phase #(.DATA_W(DATA_W)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .op_i(mid_op), .wdata_i(mid_wdata), .dq_in(mem_dq),
    .dq_out(dq_out), .dq_oe(dq_oe), .mem_oe_n(mem_oe_n),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  p_wr_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_ce_n && !mem_rw_n, 2) |-> (dq_oe && mem_oe_n));

  p_rd_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_ce_n && mem_rw_n, 2) |-> (!mem_oe_n && !dq_oe));

  p_rd_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_ce_n && mem_rw_n, 3) |-> rd_valid);

  p_quiet_after_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_ce_n, 2) |-> (mem_oe_n && !dq_oe));
endmodule

// File: tb/test_zbt_bridge.sv
module test_zbt_bridge;
  localparam int WA = 6;
  localparam int DW = 32;
  localparam int LN = DW / 8;
  localparam int PA = WA + 2;
  localparam int WORDS = 1 << WA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel_n = 1'b1, cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
  logic [PA-1:0] cpu_addr = '0;
  logic [LN-1:0] cpu_be_n = '1;
  logic [DW-1:0] cpu_wdata = '0;
  logic rd_valid, mem_clk, mem_cke_n, mem_ce_n, mem_oe_n, mem_rw_n, mem_adv_ld_n;
  logic [DW-1:0] rd_data;
  logic [LN-1:0] mem_bw_n;
  logic [WA-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;

  always #10 clk = ~clk;

  zbt_bridge #(.WADDR_W(WA), .DATA_W(DW)) i_zbt_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_sel_n(cpu_sel_n), .cpu_rd_n(cpu_rd_n),
    .cpu_wr_n(cpu_wr_n), .cpu_addr(cpu_addr), .cpu_be_n(cpu_be_n),
    .cpu_wdata(cpu_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_clk(mem_clk), .mem_cke_n(mem_cke_n), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_rw_n(mem_rw_n), .mem_adv_ld_n(mem_adv_ld_n),
    .mem_bw_n(mem_bw_n), .mem_addr(mem_addr), .mem_dq(mem_dq)
  );

  // behavioural pipelined memory: samples control at edge E, data at E+2
  logic [DW-1:0] smem [WORDS];
  logic s0_v = 1'b0, s0_w = 1'b0, s1_v = 1'b0, s1_w = 1'b0;
  logic [WA-1:0] s0_a = '0, s1_a = '0;
  logic [LN-1:0] s0_b = '1, s1_b = '1;

  initial for (int i = 0; i < WORDS; i++) smem[i] = '0;

  always @(posedge mem_clk) begin
    if (s1_v && s1_w)
      for (int l = 0; l < LN; l++)
        if (!s1_b[l]) smem[s1_a][8*l +: 8] <= mem_dq[8*l +: 8];
    s1_v <= s0_v; s1_w <= s0_w; s1_a <= s0_a; s1_b <= s0_b;
    s0_v <= !mem_ce_n && !mem_cke_n; s0_w <= !mem_rw_n;
    s0_a <= mem_addr; s0_b <= mem_bw_n;
  end

  assign mem_dq = (s1_v && !s1_w && !mem_oe_n) ? smem[s1_a] : 'z;

  // bench reference and expectation rings indexed by cycle
  logic [DW-1:0] ref_mem [WORDS];
  logic          r_acc [8], r_wr [8], r_wph [8], r_rph [8], r_rv [8];
  logic [WA-1:0] r_addr [8];
  logic [LN-1:0] r_bw [8];
  logic [DW-1:0] r_wdat [8], r_rdat [8];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic check_slot();
    int i;
    i = cyc % 8;
    check(mem_ce_n == !r_acc[i], "R1 mem_ce_n", DW'(mem_ce_n), DW'(!r_acc[i]));
    if (r_acc[i]) begin
      check(mem_addr == r_addr[i], "R2 mem_addr", DW'(mem_addr), DW'(r_addr[i]));
      check(mem_rw_n == !r_wr[i], r_wr[i] ? "R3 mem_rw_n" : "R5 mem_rw_n",
            DW'(mem_rw_n), DW'(!r_wr[i]));
      check(mem_bw_n == (r_wr[i] ? r_bw[i] : {LN{1'b1}}), r_wr[i] ? "R3 mem_bw_n" : "R5 mem_bw_n",
            DW'(mem_bw_n), DW'(r_wr[i] ? r_bw[i] : {LN{1'b1}}));
    end
    check(mem_oe_n == !r_rph[i], "R5 R6 mem_oe_n", DW'(mem_oe_n), DW'(!r_rph[i]));
    if (r_wph[i]) check(mem_dq == r_wdat[i], "R4 mem_dq", mem_dq, r_wdat[i]);
    check(rd_valid == r_rv[i], "R5 rd_valid", DW'(rd_valid), DW'(r_rv[i]));
    if (r_rv[i]) check(rd_data == r_rdat[i], "R5 R7 rd_data", rd_data, r_rdat[i]);
    check(!mem_cke_n && !mem_adv_ld_n, "R8 cke/adv", DW'({mem_cke_n, mem_adv_ld_n}), '0);
    r_acc[i] = 0; r_wr[i] = 0; r_wph[i] = 0; r_rph[i] = 0; r_rv[i] = 0;
  endtask

  // kind: 0 idle, 1 read, 2 write, 3 deselected with write strobe, 4 both strobes low
  task automatic step(input int kind, input logic [PA-1:0] a, input logic [LN-1:0] be,
                      input logic [DW-1:0] d);
    int s1, s3, s4;
    logic [WA-1:0] w;
    @(negedge clk);
    check_slot();
    s1 = (cyc + 1) % 8; s3 = (cyc + 3) % 8; s4 = (cyc + 4) % 8;
    w = a[PA-1:2];
    cpu_addr = a; cpu_be_n = be; cpu_wdata = d;
    cpu_sel_n = (kind == 0 || kind == 3);
    cpu_rd_n  = !(kind == 1 || kind == 4);
    cpu_wr_n  = !(kind == 2 || kind == 3 || kind == 4);
    if (kind == 2 || kind == 4) begin
      r_acc[s1] = 1; r_wr[s1] = 1; r_addr[s1] = w; r_bw[s1] = be;
      r_wph[s3] = 1; r_wdat[s3] = d;
      for (int l = 0; l < LN; l++)
        if (!be[l]) ref_mem[w][8*l +: 8] = d[8*l +: 8];
    end else if (kind == 1) begin
      r_acc[s1] = 1; r_wr[s1] = 0; r_addr[s1] = w;
      r_rph[s3] = 1; r_rv[s4] = 1; r_rdat[s4] = ref_mem[w];
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a + 1) * 32'h9E3779B1) ^ DW'(salt * 32'h01010101);
  endfunction

  initial begin
    for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
    for (int i = 0; i < 8; i++) begin
      r_acc[i] = 0; r_wr[i] = 0; r_wph[i] = 0; r_rph[i] = 0; r_rv[i] = 0;
      r_addr[i] = '0; r_bw[i] = '1; r_wdat[i] = '0; r_rdat[i] = '0;
    end
    repeat (5) @(posedge clk);
    // R9: reset state
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && !rd_valid, "R9 reset outputs",
          DW'({mem_ce_n, mem_oe_n, rd_valid}), DW'(3'b110));
    rst_n = 1'b1;
    // R1 R2 R3 R4: full-word write to every address, low byte bits varied
    for (int a = 0; a < WORDS; a++) step(2, PA'(a * 4 + (a % 4)), '0, pat(a, 0));
    // R5 R2: read every word back-to-back
    for (int a = 0; a < WORDS; a++) step(1, PA'(a * 4 + ((a + 1) % 4)), '1, '0);
    // R3 R7: every byte mask, write then read the same word on the next cycle
    for (int m = 0; m < 16; m++) begin
      step(2, PA'(m * 4), LN'(m), pat(m, 7));
      step(1, PA'(m * 4), '1, '0);
    end
    // R7: read then write the same word back-to-back, then read again
    for (int a = 20; a < 28; a++) begin
      step(1, PA'(a * 4), '1, '0);
      step(2, PA'(a * 4), '0, pat(a, 3));
      step(1, PA'(a * 4), '1, '0);
    end
    // R1: deselected strobes do nothing; both strobes low is a write
    for (int a = 30; a < 34; a++) begin
      step(3, PA'(a * 4), '0, 32'hDEADBEEF);
      step(0, '0, '1, '0);
      step(1, PA'(a * 4), '1, '0);
      step(4, PA'(a * 4 + 2), 4'b1010, pat(a, 9));
      step(1, PA'(a * 4), '1, '0);
    end
    // R4 R5 R6: alternating write/read on different words with idle gaps
    for (int a = 40; a < WORDS; a++) begin
      step(2, PA'(a * 4), '0, pat(a, 5));
      step(1, PA'((a - 40) * 4), '1, '0);
      if (a % 3 == 0) step(0, '0, '1, '0);
    end
    for (int i = 0; i < 6; i++) step(0, '0, '1, '0);
    // R1 R9: reset while idle brings the bus side quiet again
    rst_n = 1'b0;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && !rd_valid, "R9 reset again",
          DW'({mem_ce_n, mem_oe_n, rd_valid}), DW'(3'b110));
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule